// File: doc/BRIEF.md
# Interrupt Vector Relocation and Memory Region Decoder

This block supplies the program-space fetch address for interrupt and trap vectors and sorts every program and data address into a memory region. A 9-bit page pointer picks one 128-word page of the 16-bit program space as the vector page. Each vector occupies a four-word slot, so a vector number from 0 to 31 selects a slot inside that page. The CPU loads the pointer through a simple write port. Vector number 0 is the reset vector. It is always taken from the top page at FF80h, whatever the pointer holds. A reset also forces the pointer to all ones, so after a reset every vector comes from the top page until software moves it.

Alongside the vector path, two combinational decoders take a program address and a data address. They use three mode inputs: overlay enable, data-ROM enable and microprocessor mode. Each decoder raises exactly one bit of a one-hot region select. Reserved ranges raise a dedicated reserved bit instead of any memory select. The caller gates memory enables and bus cycles from these selects. The vector address and both decoders are combinational. Only the pointer is stored.

Top module: `vecmap_unit`

## Requirements
- R1: For vector numbers 1 to 31, vec_addr equals the page base plus four times the vector number, so vec_addr[1:0] is always 0.
- R2: For vector numbers 1 to 31, vec_addr[15:7] equals the current pointer value, so the page base is pointer times 128.
- R3: While rst_n is low, and on the first cycle after it rises, ptr_value reads 9'h1FF.
- R4: A write (ptr_wr_en high) loads ptr_wr_data into the pointer at the next rising clock edge. A vector address formed in the same cycle as the write still uses the old pointer. With ptr_wr_en low, the pointer holds its value.
- R5: Vector number 0 yields vec_addr = 16'hFF80 for every pointer value.
- R6: Program 0000h–007Fh decodes as reserved when ovly=1 and as external when ovly=0. Program 0080h–3FFFh decodes as on-chip RAM when ovly=1 and as external when ovly=0.
- R7: Program 4000h–EFFFh always decodes as external. With mp_mode=1, program F000h–FFFFh also decodes as external.
- R8: With mp_mode=0, program F000h–FEFFh decodes as on-chip ROM, FF00h–FF7Fh as reserved, and FF80h–FFFFh as on-chip vector ROM.
- R9: Data space decodes as follows, independent of mode: 0000h–005Fh as mapped registers, 0060h–007Fh as scratch RAM, 0080h–3FFFh as on-chip RAM, and 4000h–EFFFh as external.
- R10: Data F000h–FEFFh decodes as ROM when drom=1 and as external when drom=0. Data FF00h–FFFFh decodes as reserved when drom=1 and as external when drom=0.
- R11: prog_sel and data_sel are each exactly one-hot. The prog_sel bits are: 0 external, 1 on-chip RAM, 2 on-chip ROM, 3 vector ROM, 4 reserved. The data_sel bits are: 0 external, 1 mapped registers, 2 scratch RAM, 3 on-chip RAM, 4 ROM, 5 reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets the pointer to all ones |
| ptr_wr_en | input | 1 | Load the vector page pointer at the next edge |
| ptr_wr_data | input | 9 | New vector page number |
| vec_num | input | 5 | Interrupt or trap number; 0 is the reset vector |
| vec_addr | output | 16 | Program fetch address of the selected vector slot |
| ptr_value | output | 9 | Current vector page pointer |
| ovly | input | 1 | Overlay on-chip RAM into low program space |
| drom | input | 1 | Map ROM into high data space |
| mp_mode | input | 1 | 1 = microprocessor mode, 0 = microcomputer mode |
| prog_addr | input | 16 | Program address to decode |
| prog_sel | output | 5 | One-hot program region |
| data_addr | input | 16 | Data address to decode |
| data_sel | output | 6 | One-hot data region |

## Verification
The hardest case to reach is a pointer write in the same cycle as a vector request on a nonzero number. The old and new pages must differ, and the pointer must not already be all ones. Otherwise the stale and fresh addresses look the same. The stimulus first moves the pointer away from the reset page. It then issues back-to-back writes of distinct pages while vec_num stays nonzero, so every such cycle separates the old pointer from the new one. Region boundaries are covered by sweeping each range's first and last address under all eight mode combinations before the random phase.

// File: rtl/vecmap_pkg.sv
package vecmap_pkg;
  localparam int ADDR_W   = 16;
  localparam int PTR_W    = 9;
  localparam int NUM_W    = 5;
  localparam int SLOT_LG  = 2;
  localparam int PAGE_LG  = ADDR_W - PTR_W;
  localparam int PR_N     = 5;
  localparam int DR_N     = 6;

  // region boundaries (fixed memory map)
  localparam logic [ADDR_W-1:0] LOW_TOP    = 16'h007F;
  localparam logic [ADDR_W-1:0] MMR_TOP    = 16'h005F;
  localparam logic [ADDR_W-1:0] RAM_TOP    = 16'h3FFF;
  localparam logic [ADDR_W-1:0] EXT_TOP    = 16'hEFFF;
  localparam logic [ADDR_W-1:0] ROM_TOP    = 16'hFEFF;
  localparam logic [ADDR_W-1:0] GAP_TOP    = 16'hFF7F;

  typedef enum logic [2:0] {
    PR_EXT = 3'd0, PR_RAM = 3'd1, PR_ROM = 3'd2, PR_VEC = 3'd3, PR_RSV = 3'd4
  } prog_rgn_e;

  typedef enum logic [2:0] {
    DR_EXT = 3'd0, DR_MMR = 3'd1, DR_SCR = 3'd2, DR_RAM = 3'd3,
    DR_ROM = 3'd4, DR_RSV = 3'd5
  } data_rgn_e;

  // slot address: page base plus four words per vector; number 0 pinned to top page
  function automatic logic [ADDR_W-1:0] vec_address(
    input logic [PTR_W-1:0] ptr,
    input logic [NUM_W-1:0] num
  );
    logic [PTR_W-1:0]   page;
    logic [PAGE_LG-1:0] offs;
    page = (num == '0) ? '1 : ptr;
    offs = PAGE_LG'({num, {SLOT_LG{1'b0}}});
    return {page, offs};
  endfunction

  function automatic prog_rgn_e prog_region(
    input logic [ADDR_W-1:0] a,
    input logic ovl,
    input logic mp
  );
    if (a <= LOW_TOP)      return ovl ? PR_RSV : PR_EXT;
    else if (a <= RAM_TOP) return ovl ? PR_RAM : PR_EXT;
    else if (a <= EXT_TOP) return PR_EXT;
    else if (mp)           return PR_EXT;
    else if (a <= ROM_TOP) return PR_ROM;
    else if (a <= GAP_TOP) return PR_RSV;
    else                   return PR_VEC;
  endfunction

  function automatic data_rgn_e data_region(
    input logic [ADDR_W-1:0] a,
    input logic dr
  );
    if (a <= MMR_TOP)      return DR_MMR;
    else if (a <= LOW_TOP) return DR_SCR;
    else if (a <= RAM_TOP) return DR_RAM;
    else if (a <= EXT_TOP) return DR_EXT;
    else if (!dr)          return DR_EXT;
    else if (a <= ROM_TOP) return DR_ROM;
    else                   return DR_RSV;
  endfunction
endpackage

// File: rtl/vecmap_ptr_reg.sv
module vecmap_ptr_reg #(
  parameter int PTR_W = vecmap_pkg::PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_data,
  output logic [PTR_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '1;
    else if (wr_en) ptr_q <= wr_data;
  end
endmodule

// File: rtl/vecmap_vec_gen.sv
module vecmap_vec_gen
  import vecmap_pkg::*;
(
  input  logic [PTR_W-1:0]  ptr,
  input  logic [NUM_W-1:0]  num,
  output logic [ADDR_W-1:0] addr
);
  always_comb addr = vec_address(ptr, num);
endmodule

// File: rtl/vecmap_prog_dec.sv
module vecmap_prog_dec
  import vecmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ovl,
  input  logic              mp,
  output logic [PR_N-1:0]   sel
);
  prog_rgn_e rgn;
  always_comb rgn = prog_region(addr, ovl, mp);

  for (genvar i = 0; i < PR_N; i++) begin : g_sel
    assign sel[i] = (rgn == prog_rgn_e'(i));
  end
endmodule

// File: rtl/vecmap_data_dec.sv
module vecmap_data_dec
  import vecmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              dr,
  output logic [DR_N-1:0]   sel
);
  data_rgn_e rgn;
  always_comb rgn = data_region(addr, dr);

  for (genvar i = 0; i < DR_N; i++) begin : g_sel
    assign sel[i] = (rgn == data_rgn_e'(i));
  end
endmodule

// File: rtl/vecmap_unit.sv
module vecmap_unit
  import vecmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr_en,
  input  logic [PTR_W-1:0]  ptr_wr_data,
  input  logic [NUM_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [PTR_W-1:0]  ptr_value,
  input  logic              ovly,
  input  logic              drom,
  input  logic              mp_mode,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic [PR_N-1:0]   prog_sel,
  input  logic [ADDR_W-1:0] data_addr,
  output logic [DR_N-1:0]   data_sel
);
  logic [PTR_W-1:0] ptr_q;

  vecmap_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr_en),
    .wr_data(ptr_wr_data), .ptr_q(ptr_q)
  );

  vecmap_vec_gen u_vec (.ptr(ptr_q), .num(vec_num), .addr(vec_addr));

  vecmap_prog_dec u_pdec (
    .addr(prog_addr), .ovl(ovly), .mp(mp_mode), .sel(prog_sel)
  );

  vecmap_data_dec u_ddec (.addr(data_addr), .dr(drom), .sel(data_sel));

  assign ptr_value = ptr_q;
endmodule

// File: rtl/vecmap_unit_chk.sv
module vecmap_unit_chk
  import vecmap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_wr_en,
  input logic [PTR_W-1:0]  ptr_wr_data,
  input logic [NUM_W-1:0]  vec_num,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [PTR_W-1:0]  ptr_value,
  input logic [PR_N-1:0]   prog_sel,
  input logic [DR_N-1:0]   data_sel
);
  AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr[SLOT_LG-1:0] == '0); // R1
  AST_PAGE_FROM_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_num != '0) |-> (vec_addr[ADDR_W-1:PAGE_LG] == ptr_value)); // R2
  AST_PTR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ptr_value == '1)); // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |=> (ptr_value == $past(ptr_wr_data))); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr_en |=> $stable(ptr_value)); // R4
  AST_RESET_VEC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_num == '0) |-> (vec_addr == 16'hFF80)); // R5
  AST_PROG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(prog_sel) == 1); // R11
  AST_DATA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(data_sel) == 1); // R11
endmodule

bind vecmap_unit vecmap_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
  .vec_num(vec_num), .vec_addr(vec_addr), .ptr_value(ptr_value),
  .prog_sel(prog_sel), .data_sel(data_sel)
);

// File: tb/vecmap_unit_tb.sv
module vecmap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr_en = 1'b0;
  logic [8:0]  ptr_wr_data = '0;
  logic [4:0]  vec_num = '0;
  logic [15:0] vec_addr;
  logic [8:0]  ptr_value;
  logic        ovly = 1'b0, drom = 1'b0, mp_mode = 1'b0;
  logic [15:0] prog_addr = '0, data_addr = '0;
  logic [4:0]  prog_sel;
  logic [5:0]  data_sel;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int ref_ptr = 511;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  vecmap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .vec_num(vec_num), .vec_addr(vec_addr), .ptr_value(ptr_value),
    .ovly(ovly), .drom(drom), .mp_mode(mp_mode),
    .prog_addr(prog_addr), .prog_sel(prog_sel),
    .data_addr(data_addr), .data_sel(data_sel)
  );

  // behavioural model of the pointer
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_ptr <= 511;
    else if (ptr_wr_en) ref_ptr <= int'(ptr_wr_data);
  end

  function automatic int model_vec(int p, int n);
    if (n == 0) return 'hFF80 + 0;
    return p * 128 + n * 4;
  endfunction

  // program regions: 0 ext, 1 ram, 2 rom, 3 vec, 4 reserved
  function automatic int model_prog(int a, bit ov, bit mp);
    if (a < 'h80)    return ov ? 4 : 0;
    if (a < 'h4000)  return ov ? 1 : 0;
    if (a < 'hF000)  return 0;
    if (mp)          return 0;
    if (a < 'hFF00)  return 2;
    if (a < 'hFF80)  return 4;
    return 3;
  endfunction

  // data regions: 0 ext, 1 regs, 2 scratch, 3 ram, 4 rom, 5 reserved
  function automatic int model_data(int a, bit dr);
    if (a < 'h60)    return 1;
    if (a < 'h80)    return 2;
    if (a < 'h4000)  return 3;
    if (a < 'hF000)  return 0;
    if (!dr)         return 0;
    if (a < 'hFF00)  return 4;
    return 5;
  endfunction

  task automatic check(int act, int exp, string req, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int pa = int'(prog_addr), da = int'(data_addr);
    string ptag, dtag, vtag;
    check(int'(ptr_value), ref_ptr, rst_n ? "R4" : "R3", "ptr_value");
    vtag = (vec_num == 0) ? "R5" : (ptr_wr_en ? "R4" : "R1 R2");
    check(int'(vec_addr), model_vec(ref_ptr, int'(vec_num)), vtag, "vec_addr");
    ptag = (pa < 'h4000) ? "R6" : ((mp_mode || pa < 'hF000) ? "R7" : "R8");
    check(int'(prog_sel), 1 << model_prog(pa, ovly, mp_mode), ptag, "prog_sel");
    dtag = (da < 'hF000) ? "R9" : "R10";
    check(int'(data_sel), 1 << model_data(da, drom), dtag, "data_sel");
    check($countones(prog_sel) + $countones(data_sel), 2, "R11", "onehot");
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  int bounds[14] = '{'h0000, 'h005F, 'h0060, 'h007F, 'h0080, 'h3FFF, 'h4000,
                     'hEFFF, 'hF000, 'hFEFF, 'hFF00, 'hFF7F, 'hFF80, 'hFFFF};

  initial begin
    // R3: reset state
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check(int'(ptr_value), 511, "R3", "ptr after reset");
    vec_num = 5'd3;
    step(); // R1 R2: vector on reset page
    // boundary sweep under all mode combinations (R6..R10)
    for (int m = 0; m < 8; m++) begin
      for (int b = 0; b < 14; b++) begin
        ovly = m[0]; drom = m[1]; mp_mode = m[2];
        prog_addr = 16'(bounds[b]); data_addr = 16'(bounds[b]);
        step();
      end
    end
    // R4: move pointer, then writes with distinct pages and live requests
    ptr_wr_en = 1'b1; ptr_wr_data = 9'h012; vec_num = 5'd7;
    step();
    ptr_wr_en = 1'b0;
    step();
    check(int'(vec_addr), 'h12 * 128 + 28, "R4", "new page used");
    for (int k = 0; k < 6; k++) begin
      ptr_wr_en = 1'b1; ptr_wr_data = 9'(20 + k * 37); vec_num = 5'(k + 1);
      step();
    end
    ptr_wr_en = 1'b0; vec_num = 5'd0;
    step(); // R5 with relocated pointer
    vec_num = 5'd31;
    step(); // R1 top slot
    // random phase
    for (int i = 0; i < 3000; i++) begin
      ptr_wr_en = ($urandom % 4) == 0;
      ptr_wr_data = 9'($urandom);
      vec_num = 5'($urandom);
      {ovly, drom, mp_mode} = 3'($urandom);
      prog_addr = 16'($urandom);
      data_addr = 16'($urandom);
      step();
    end
    // R3 again: reset mid-run from a relocated pointer
    ptr_wr_en = 1'b1; ptr_wr_data = 9'h055;
    step();
    ptr_wr_en = 1'b0;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    check(int'(ptr_value), 511, "R3", "ptr after second reset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule